// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This unit turns a four-bit condition selector and the five processor status flags (overflow, carry, zero, sign, saturation) into a single "condition met" bit. Conditional branch logic and set-on-condition logic both use that bit. The mapping is fixed at sixteen entries. Each code with bit 3 set is the complement of the code with bit 3 clear, with two exceptions. Selector 5 is always true. Selector 13 tests the saturation flag instead of being the complement of selector 5.

The evaluation is purely combinational. A parameter selects whether the result is also captured in a register. In registered mode the result is loaded when the valid strobe is high and appears one clock later. When the strobe is low, the register keeps its value. The selector input may be wider than four bits. Only its low four bits are decoded.

Top module: `cond_eval`

## Requirements
- R1: Selector 0x0 gives 1 exactly when overflow is set. Selector 0x8 gives 1 exactly when overflow is clear.
- R2: Selector 0x1 gives 1 exactly when carry is set. Selector 0x9 gives 1 exactly when carry is clear.
- R3: Selector 0x2 gives 1 exactly when zero is set. Selector 0xA gives 1 exactly when zero is clear.
- R4: Selector 0x3 gives 1 when carry OR zero is set. Selector 0xB gives 1 only when both are clear.
- R5: Selector 0x4 gives 1 exactly when sign is set. Selector 0xC gives 1 exactly when sign is clear.
- R6: Selector 0x5 gives 1 for every flag pattern.
- R7: Selector 0xD gives 1 exactly when saturation is set. It is not the complement of selector 0x5.
- R8: Selector 0x6 gives sign XOR overflow. Selector 0xE gives its complement.
- R9: Selector 0x7 gives (sign XOR overflow) OR zero. Selector 0xF gives its complement.
- R10: Selector bits above bit 3 have no effect on the result.
- R11: With REGISTERED=1, met_out takes the evaluated result one clock after a cycle in which valid_in is high. met_out holds its value after a cycle in which valid_in is low.
- R12: A synchronous active-high reset clears the registered met_out to 0.
- R13: With REGISTERED=0, met_out follows the current inputs in the same cycle.

The flags_in bit layout is: bit 0 overflow, bit 1 carry, bit 2 zero, bit 3 sign, bit 4 saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used only in registered mode) |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Strobe that loads the registered result |
| code_in | input | CODE_W | Condition selector; only bits 3:0 are decoded |
| flags_in | input | 5 | Status flags {sat, sign, zero, carry, overflow} |
| met_out | output | 1 | Condition met |

## Verification
Two inputs are hard to reach from the ports: the two special selectors, 5 and 13, and the saturation flag, which no other selector reads. An exhaustive sweep covers both. It drives every selector against all 32 flag patterns, so each selector gets both polarities of every flag it reads. It also drives the combinations in which selector 13 would differ from a plain complement of selector 5. Changing upper selector bits and valid-low idle cycles are mixed into the sweep, so the ignore and hold behaviour is exercised together with the decode.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    localparam int COND_W = 4;
    localparam int FLAG_W = 5;

    typedef struct packed {
        logic sat;
        logic sgn;
        logic zer;
        logic cry;
        logic ovf;
    } psw_flags_t;

    typedef enum logic [COND_W-2:0] {
        BASE_OVF     = 3'd0,
        BASE_CRY     = 3'd1,
        BASE_ZER     = 3'd2,
        BASE_CRY_ZER = 3'd3,
        BASE_SGN     = 3'd4,
        BASE_SPECIAL = 3'd5,
        BASE_LESS    = 3'd6,
        BASE_LESS_EQ = 3'd7
    } base_sel_e;

    typedef struct packed {
        logic      negate;
        base_sel_e sel;
    } cond_code_t;

    function automatic logic signed_less(psw_flags_t f);
        return f.sgn ^ f.ovf;
    endfunction

endpackage

// File: rtl/cond_base_sel.sv
module cond_base_sel
    import cond_eval_pkg::*;
(
    input  base_sel_e  sel,
    input  psw_flags_t flags,
    output logic       base
);
    always_comb begin
        unique case (sel)
            BASE_OVF:     base = flags.ovf;
            BASE_CRY:     base = flags.cry;
            BASE_ZER:     base = flags.zer;
            BASE_CRY_ZER: base = flags.cry | flags.zer;
            BASE_SGN:     base = flags.sgn;
            BASE_SPECIAL: base = flags.sat;
            BASE_LESS:    base = signed_less(flags);
            BASE_LESS_EQ: base = signed_less(flags) | flags.zer;
            default:      base = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_polarity.sv
module cond_polarity (
    input  logic negate,
    input  logic special,
    input  logic base,
    output logic met
);
    always_comb begin
        if (special)
            met = negate ? base : 1'b1;
        else
            met = base ^ negate;
    end
endmodule

// File: rtl/cond_out_stage.sv
module cond_out_stage #(
    parameter bit REGISTERED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic d,
    output logic q
);
    generate
        if (REGISTERED) begin : g_reg
            logic q_r;
            always_ff @(posedge clk) begin
                if (rst)
                    q_r <= 1'b0;
                else if (valid)
                    q_r <= d;
            end
            assign q = q_r;
        end else begin : g_comb
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_eval_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [CODE_W-1:0] code_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              met_out
);
    cond_code_t code;
    psw_flags_t flags;
    logic       base_term;
    logic       met_comb;

    assign code  = cond_code_t'(code_in[COND_W-1:0]);
    assign flags = psw_flags_t'(flags_in);

    cond_base_sel u_base (
        .sel   (code.sel),
        .flags (flags),
        .base  (base_term)
    );

    cond_polarity u_pol (
        .negate  (code.negate),
        .special (code.sel == BASE_SPECIAL),
        .base    (base_term),
        .met     (met_comb)
    );

    cond_out_stage #(.REGISTERED(REGISTERED)) u_out (
        .clk   (clk),
        .rst   (rst),
        .valid (valid_in),
        .d     (met_comb),
        .q     (met_out)
    );

    // R1
    ovf_code_chk: assert property (@(posedge clk) disable iff (rst)
        (code_in[COND_W-1:0] == 4'h0) |-> (met_comb == flags_in[0]));

    // R6
    always_true_chk: assert property (@(posedge clk) disable iff (rst)
        (code_in[COND_W-1:0] == 4'h5) |-> met_comb);

    // R7
    sat_code_chk: assert property (@(posedge clk) disable iff (rst)
        (code_in[COND_W-1:0] == 4'hD) |-> (met_comb == flags_in[4]));

    // R10
    upper_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(code_in[COND_W-1:0]) && $stable(flags_in) && !$stable(code_in))
        |-> $stable(met_comb));

    generate
        if (REGISTERED) begin : g_reg_chk
            // R11
            load_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
                valid_in |=> (met_out == $past(met_comb)));
            // R11
            hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !valid_in |=> $stable(met_out));
        end else begin : g_comb_chk
            // R13
            comb_follow_chk: assert property (@(posedge clk) disable iff (rst)
                met_out == met_comb);
        end
    endgenerate
endmodule

// File: tb/test_cond_eval.sv
module test_cond_eval;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          valid_in;
    logic [CW-1:0] code_in;
    logic [4:0]    flags_in;
    logic          met_out;
    logic          met_comb_out;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    logic exp_reg;

    always #4 clk = ~clk;

    cond_eval #(.CODE_W(CW), .REGISTERED(1'b1)) i_cond_eval (
        .clk(clk), .rst(rst), .valid_in(valid_in), .code_in(code_in),
        .flags_in(flags_in), .met_out(met_out));

    cond_eval #(.CODE_W(CW), .REGISTERED(1'b0)) i_cond_eval_comb (
        .clk(clk), .rst(rst), .valid_in(valid_in), .code_in(code_in),
        .flags_in(flags_in), .met_out(met_comb_out));

    // Behavioural model from the requirements: flags {sat,sgn,zer,cry,ovf}
    function automatic logic ref_met(int c, logic [4:0] f);
        logic ov, cy, z, s, sa, lt;
        ov = f[0]; cy = f[1]; z = f[2]; s = f[3]; sa = f[4];
        lt = (s != ov);
        case (c & 15)
            0:  return ov;
            1:  return cy;
            2:  return z;
            3:  return cy || z;
            4:  return s;
            5:  return 1'b1;
            6:  return lt;
            7:  return lt || z;
            8:  return !ov;
            9:  return !cy;
            10: return !z;
            11: return !(cy || z);
            12: return !s;
            13: return sa;
            14: return !lt;
            default: return !(lt || z);
        endcase
    endfunction

    function automatic string tag_of(int c);
        case (c & 15)
            0, 8:   return "R1";
            1, 9:   return "R2";
            2, 10:  return "R3";
            3, 11:  return "R4";
            4, 12:  return "R5";
            5:      return "R6";
            13:     return "R7";
            6, 14:  return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b code=%h flags=%b",
                     tag, act, exp, code_in, flags_in);
        end
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; valid_in = 1'b0; code_in = '0; flags_in = '0;
        exp_reg = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", met_out, 1'b0);
        rst = 1'b0;

        // Exhaustive sweep with varying upper bits and idle cycles
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 32; f++) begin
                logic [CW-5:0] up;
                logic          v;
                up = CW'((c * 7 + f * 3) % 4);
                v  = ((c + f) % 5) != 0;
                code_in  = {up[1:0], 4'(c)};
                flags_in = 5'(f);
                valid_in = v;
                #1;
                chk(tag_of(c), met_comb_out, ref_met(c, 5'(f)));
                chk("R13", met_comb_out, ref_met(c, 5'(f)));
                @(posedge clk);
                if (v) exp_reg = ref_met(c, 5'(f));
                @(negedge clk);
                chk(v ? "R11" : "R11_hold", met_out, exp_reg);
            end
        end

        // R10: all upper selector bits set
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 32; f += 5) begin
                code_in  = {2'b11, 4'(c)};
                flags_in = 5'(f);
                valid_in = 1'b1;
                #1;
                chk("R10", met_comb_out, ref_met(c, 5'(f)));
                @(posedge clk);
                exp_reg = ref_met(c, 5'(f));
                @(negedge clk);
                chk("R10", met_out, exp_reg);
            end
        end

        // R7: selector 13 with saturation clear is 0, unlike selector 5
        code_in = 6'h0D; flags_in = 5'b01111; valid_in = 1'b1;
        #1;
        chk("R7", met_comb_out, 1'b0);
        code_in = 6'h05; flags_in = 5'b00000;
        #1;
        chk("R6", met_comb_out, 1'b1);

        // R12: reset mid-run while a true condition is strobed
        @(posedge clk);
        @(negedge clk);
        chk("R11", met_out, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R12", met_out, 1'b0);
        rst = 1'b0; valid_in = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R11_hold", met_out, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule